// File: doc/BRIEF.md
# Quad Switch Serial Control Slave

This block is the serial control front end of a four-channel isolated switch. A host drives fixed 24-bit frames over a mode-0 SPI link. Each frame is a command byte, a register byte and a data byte. The block decodes the frame into a switch-enable write, a status or diagnostics read, or a diagnostics clear. Per-channel fault flags arrive as input bits and are held until software clears them. Whenever any flag is held, the block pulls a shared open-drain fault line.

Several devices can sit on one chain. Bits [5:4] of the command byte carry a chip address. A device that sees address zero executes the frame. Any other device re-sends the complete frame on its own downstream serial port, with that field lowered by one. The downstream port has its own clock and select, generated from the system clock.

A build-time option models parts whose switches are driven by parallel pins. In that mode the outputs follow the pins, and a switch-enable write only reports status.

The SPI pins are assumed to be synchronous to `clk` already, and the serial clock is assumed to be at least four system clocks per period.

Top module: `sw_quad_ctl`

## Requirements
- R1: A frame takes effect only when its 24th bit is received on a rising serial clock edge while select is low. If select rises earlier, the frame changes no register and nothing is forwarded.
- R2: Command bit 6 set means read and clear means write. Command bits 7 and 3:0 have no effect.
- R3: In the serial-control build, a write to register 0x03 sets the switch outputs from data bits 3:0, where bit n drives channel n+1. The write appears on the outputs one clock after the 24th bit.
- R4: A read of register 0x03 returns the current switch state in bits 3:0, with zeros in bits 7:4.
- R5: Each channel has four fault flags, and each flag is sticky once its input is seen high. Register 0x01 returns channel 1 flags in bits 3:0 and channel 2 flags in bits 7:4. Register 0x02 holds channels 3 and 4 the same way.
- R6: Register 0x00 returns, in bit n, whether channel n+1 holds any flag. Bits 7:4 read zero.
- R7: A write to 0x05 clears the held flags of each channel whose data bit is set. A flag whose input is still high stays set. Register 0x05, unmapped addresses, and writes to read-only registers have no effect and read as zero.
- R8: For read frames, the read data is shifted out on MISO during the third byte, most significant bit first, and is captured when the second byte completes. MISO is low at all other times and for write frames.
- R9: A frame with a nonzero chip address changes nothing locally, returns zeros on MISO, and is re-sent downstream with the chip address minus one.
- R10: A forwarded frame is sent with downstream select low for exactly 24 clock pulses, most significant bit first. Each bit is valid before its rising edge, and the downstream clock is low whenever select is high.
- R11: In the parallel-input build, the switch outputs equal the parallel pins. A write to 0x03 leaves them unchanged and returns the pin state on MISO.
- R12: The fault pull-down output is high exactly while any held flag is set.
- R13: After reset all switches are off, no flag is held, MISO is low and the downstream port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_sclk | input | 1 | Host serial clock (mode 0) |
| spi_mosi | input | 1 | Host serial data in |
| spi_miso | output | 1 | Serial read data out |
| par_in | input | 4 | Parallel switch pins (parallel build) |
| diag_in | input | 16 | Fault flag inputs, four per channel, channel 1 lowest |
| sw_out | output | 4 | Switch drive, bit n is channel n+1 |
| fault_pull | output | 1 | High pulls the shared fault line low |
| fwd_cs_n | output | 1 | Downstream chip select |
| fwd_sclk | output | 1 | Downstream serial clock |
| fwd_mosi | output | 1 | Downstream serial data |

## Verification
The bench sends a frame that stops four bits short, both to this device and to a later device. A design that counted loosely would change the switches or emit a partial downstream frame. Clears are issued while a flag input is still high, and clears are masked to a single channel. A wrong priority would drop a live fault, and a wrong mask would release the wrong channel's fault line.

Forwarded frames are decoded from the downstream pins and compared with the decremented address. An off-by-one in the decrement, or any local execution of a frame meant for another device, therefore shows up directly. A parallel-build twin receives the same switch writes. It must keep its outputs on the pins and report them on MISO, where the serial build reports zeros.

// File: rtl/sw_ctl_pkg.sv
// Shared constants and register codes for the quad switch control slave.
package sw_ctl_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 3 * BYTE_W;
    localparam int FLAGS      = BYTE_W / 2;   // fault flags per channel
    localparam int RD_BIT     = 6;            // command bit selecting read

    localparam logic [7:0] REG_MASTER = 8'h00;
    localparam logic [7:0] REG_SWITCH = 8'h03;
    localparam logic [7:0] REG_CLEAR  = 8'h05;
endpackage

// File: rtl/swc_frame_rx.sv
// Frame receiver: counts 24 rising serial clock edges while select is low,
// flags header and frame completion, and shifts the reply out on MISO.
// Assumes cs_n/sclk/mosi are synchronous to clk and slower than clk/4.
module swc_frame_rx
    import sw_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  mosi,
    input  logic [BYTE_W-1:0]     tx_load,
    output logic                  hdr_done,
    output logic                  hdr_rd,
    output logic [1:0]            hdr_chip,
    output logic [BYTE_W-1:0]     hdr_reg,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  miso
);
    localparam int CW = $clog2(FRAME_BITS + 1);

    logic                  sclk_q;
    logic                  rise;
    logic [CW-1:0]         cnt;
    logic [FRAME_BITS-2:0] sh;
    logic [BYTE_W-1:0]     tx;

    assign rise       = sclk && !sclk_q && !cs_n;
    assign hdr_done   = rise && (cnt == CW'(2 * BYTE_W - 1));
    assign frame_done = rise && (cnt == CW'(FRAME_BITS - 1));
    assign frame      = {sh, mosi};
    assign hdr_rd     = sh[2 * BYTE_W - 3];
    assign hdr_chip   = sh[2 * BYTE_W - 4 -: 2];
    assign hdr_reg    = {sh[BYTE_W-2:0], mosi};
    assign miso       = tx[BYTE_W-1];

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Shift in data bits and count them, saturating at a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (cs_n) begin
            cnt <= '0;
        end else if (rise && cnt != CW'(FRAME_BITS)) begin
            sh  <= frame[FRAME_BITS-2:0];
            cnt <= cnt + CW'(1);
        end
    end

    // Reply shifter: loaded after the header, shifted during the data byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)
            tx <= '0;
        else if (hdr_done)
            tx <= tx_load;
        else if (rise && cnt >= CW'(2 * BYTE_W) && cnt < CW'(FRAME_BITS - 1))
            tx <= {tx[BYTE_W-2:0], 1'b0};
    end
endmodule

// File: rtl/swc_regs.sv
// Register file: switch enable, sticky per-channel fault flags with masked
// set-dominant clear, and the read multiplexer. Assumes NCH is 2 or 4.
module swc_regs
    import sw_ctl_pkg::*;
#(
    parameter int NCH         = 4,
    parameter bit PARALLEL_IN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wr_reg,
    input  logic [NCH-1:0]       wr_mask,
    input  logic [BYTE_W-1:0]    rd_reg,
    input  logic [NCH-1:0]       par_in,
    input  logic [NCH*FLAGS-1:0] diag_in,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NCH-1:0]       sw_out,
    output logic                 fault_pull
);
    localparam int NPAIR = NCH / 2;

    logic [NCH-1:0]             en_q;
    logic [NCH-1:0][FLAGS-1:0]  lat;
    logic [NCH-1:0]             any_ch;
    logic [NPAIR-1:0][BYTE_W-1:0] pair;
    logic                       clr_hit;

    assign clr_hit    = wr_en && (wr_reg == REG_CLEAR);
    assign fault_pull = |any_ch;

    // Select the switch source by build option.
    always_comb begin
        if (PARALLEL_IN) sw_out = par_in;
        else             sw_out = en_q;
    end

    // Switch enable register, written only in the serial-control build.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && wr_reg == REG_SWITCH && !PARALLEL_IN)
            en_q <= wr_mask;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Sticky flags: new faults win over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lat[c] <= '0;
            else
                lat[c] <= ((clr_hit && wr_mask[c]) ? '0 : lat[c])
                          | diag_in[c*FLAGS +: FLAGS];
        end
        assign any_ch[c] = |lat[c];
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair[p] = {lat[2*p+1], lat[2*p]};
    end

    // Read multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        if (rd_reg == REG_MASTER) rd_data = BYTE_W'(any_ch);
        if (rd_reg == REG_SWITCH) rd_data = BYTE_W'(sw_out);
        for (int p = 0; p < NPAIR; p++)
            if (rd_reg == BYTE_W'(p + 1)) rd_data = pair[p];
    end
endmodule

// File: rtl/swc_fwd.sv
// Downstream retransmitter: replays a captured 24-bit frame as a mode-0
// serial transfer, HALF system clocks per clock phase. A start that comes
// while a replay is running is dropped (host pacing is assumed to prevent it).
module swc_fwd
    import sw_ctl_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  fwd_cs_n,
    output logic                  fwd_sclk,
    output logic                  fwd_mosi
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(FRAME_BITS);

    logic                  busy;
    logic                  phase;
    logic [TW-1:0]         tick;
    logic [BW-1:0]         bitn;
    logic [FRAME_BITS-1:0] sh;

    assign fwd_cs_n = !busy;
    assign fwd_mosi = busy && sh[FRAME_BITS-1];

    // Phase sequencer: low phase presents a bit, high phase clocks it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; phase <= 1'b0; tick <= '0; bitn <= '0;
            sh <= '0; fwd_sclk <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1; phase <= 1'b0; tick <= '0; bitn <= '0;
                sh <= frame;
            end
        end else if (tick != TW'(HALF - 1)) begin
            tick <= tick + TW'(1);
        end else begin
            tick <= '0;
            if (!phase) begin
                phase    <= 1'b1;
                fwd_sclk <= 1'b1;
            end else begin
                phase    <= 1'b0;
                fwd_sclk <= 1'b0;
                if (bitn == BW'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                end else begin
                    bitn <= bitn + BW'(1);
                    sh   <= {sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/sw_quad_ctl.sv
// Top of the quad switch serial control slave: routes completed frames to
// the local registers (chip address zero) or to the downstream replay with
// the chip address lowered by one, and prepares the MISO reply.
module sw_quad_ctl
    import sw_ctl_pkg::*;
#(
    parameter int NCH         = 4,
    parameter bit PARALLEL_IN = 1'b0,
    parameter int FWD_HALF    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_cs_n,
    input  logic                 spi_sclk,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic [NCH-1:0]       par_in,
    input  logic [NCH*FLAGS-1:0] diag_in,
    output logic [NCH-1:0]       sw_out,
    output logic                 fault_pull,
    output logic                 fwd_cs_n,
    output logic                 fwd_sclk,
    output logic                 fwd_mosi
);
    logic                  hdr_done, hdr_rd, frame_done;
    logic [1:0]            hdr_chip;
    logic [BYTE_W-1:0]     hdr_reg, rd_data, tx_load, f_cmd;
    logic [FRAME_BITS-1:0] frame, fwd_frame;
    logic                  local_hit, wr_en, fwd_start;

    assign f_cmd     = frame[FRAME_BITS-1 -: BYTE_W];
    assign local_hit = (f_cmd[5:4] == 2'd0);
    assign wr_en     = frame_done && local_hit && !f_cmd[RD_BIT];
    assign fwd_start = frame_done && !local_hit;
    assign fwd_frame = {f_cmd[7:6], f_cmd[5:4] - 2'd1, f_cmd[3:0],
                        frame[2*BYTE_W-1:0]};

    // Reply selection: reads, or status for parallel-build enable writes.
    always_comb begin
        tx_load = '0;
        if (hdr_chip == 2'd0 &&
            (hdr_rd || (PARALLEL_IN && hdr_reg == REG_SWITCH)))
            tx_load = rd_data;
    end

    swc_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
        .mosi(spi_mosi), .tx_load(tx_load), .hdr_done(hdr_done),
        .hdr_rd(hdr_rd), .hdr_chip(hdr_chip), .hdr_reg(hdr_reg),
        .frame_done(frame_done), .frame(frame), .miso(spi_miso)
    );

    swc_regs #(.NCH(NCH), .PARALLEL_IN(PARALLEL_IN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_reg(frame[2*BYTE_W-1 -: BYTE_W]), .wr_mask(frame[NCH-1:0]),
        .rd_reg(hdr_reg), .par_in(par_in), .diag_in(diag_in),
        .rd_data(rd_data), .sw_out(sw_out), .fault_pull(fault_pull)
    );

    swc_fwd #(.HALF(FWD_HALF)) u_fwd (
        .clk(clk), .rst_n(rst_n), .start(fwd_start), .frame(fwd_frame),
        .fwd_cs_n(fwd_cs_n), .fwd_sclk(fwd_sclk), .fwd_mosi(fwd_mosi)
    );
endmodule

// File: rtl/sw_quad_ctl_chk.sv
// Port-level checker for sw_quad_ctl, attached by bind below.
module sw_quad_ctl_chk #(
    parameter int NCH         = 4,
    parameter bit PARALLEL_IN = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             spi_miso,
    input logic [NCH-1:0]   par_in,
    input logic [NCH*4-1:0] diag_in,
    input logic [NCH-1:0]   sw_out,
    input logic             fault_pull,
    input logic             fwd_cs_n,
    input logic             fwd_sclk
);
    p_fault_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_in != '0) |=> fault_pull);

    p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pull && spi_cs_n) |=> fault_pull);

    p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso);

    p_fwd_clk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_cs_n |-> !fwd_sclk);

    if (PARALLEL_IN) begin : g_par
        p_par_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            sw_out == par_in);
    end else begin : g_ser
        p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            spi_cs_n |=> $stable(sw_out));
    end
endmodule

bind sw_quad_ctl sw_quad_ctl_chk #(.NCH(NCH), .PARALLEL_IN(PARALLEL_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .par_in(par_in), .diag_in(diag_in), .sw_out(sw_out),
    .fault_pull(fault_pull), .fwd_cs_n(fwd_cs_n), .fwd_sclk(fwd_sclk)
);

// File: tb/sw_quad_ctl_test.sv
// Bench: behavioural model of switch state and held flags compared every
// clock, plus per-frame checks of MISO replies and downstream frames.
module sw_quad_ctl_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [3:0]  par_in = 4'b0101;
    logic [15:0] diag_in = '0;
    logic miso0, miso1, fp0, fp1, fcs0, fsk0, fmo0, fcs1, fsk1, fmo1;
    logic [3:0] sw0, sw1;

    int n_cmp = 0, n_bad = 0;
    bit chk_on = 0, done = 0;
    logic [3:0]  m_en = '0;
    logic [15:0] m_lat = '0;
    logic [23:0] exp_q[$], got_q[$];

    always #4 clk = !clk;

    sw_quad_ctl uut (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso0), .par_in(par_in), .diag_in(diag_in),
        .sw_out(sw0), .fault_pull(fp0), .fwd_cs_n(fcs0), .fwd_sclk(fsk0),
        .fwd_mosi(fmo0));

    sw_quad_ctl #(.PARALLEL_IN(1'b1)) uut_par (.clk(clk), .rst_n(rst_n),
        .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso1),
        .par_in(par_in), .diag_in(diag_in), .sw_out(sw1), .fault_pull(fp1),
        .fwd_cs_n(fcs1), .fwd_sclk(fsk1), .fwd_mosi(fmo1));

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a, input bit par);
        logic [7:0] r = '0;
        case (a)
            8'h00: for (int c = 0; c < 4; c++) r[c] = |m_lat[4*c +: 4];
            8'h01: r = m_lat[7:0];
            8'h02: r = m_lat[15:8];
            8'h03: r = par ? {4'b0, par_in} : {4'b0, m_en};
            default: r = '0;
        endcase
        return r;
    endfunction

    // Model effect of a complete frame, applied as its last clock goes high.
    task automatic apply(input logic [7:0] c, a, d);
        if (c[5:4] != 2'd0) begin
            exp_q.push_back({c[7:6], c[5:4] - 2'd1, c[3:0], a, d});
        end else if (!c[6]) begin
            if (a == 8'h03) m_en = d[3:0];
            if (a == 8'h05)
                for (int k = 0; k < 4; k++)
                    if (d[k]) m_lat[4*k +: 4] = diag_in[4*k +: 4];
        end
    endtask

    task automatic xfer(input logic [7:0] c, a, d, input int nb,
                        output logic [7:0] r0, output logic [7:0] r1);
        logic [23:0] w;
        w = {c, a, d}; r0 = '0; r1 = '0;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk) sclk = 1'b0; mosi = w[23-i];
            @(negedge clk);
            @(negedge clk);
            if (i >= 16) begin r0 = {r0[6:0], miso0}; r1 = {r1[6:0], miso1}; end
            sclk = 1'b1;
            if (i == 23) apply(c, a, d);
            @(negedge clk);
        end
        @(negedge clk) sclk = 1'b0;
        @(negedge clk) cs_n = 1'b1; mosi = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_diag(input logic [15:0] v);
        @(negedge clk) diag_in = v; m_lat = m_lat | v;
        @(negedge clk);
    endtask

    task automatic check_fwd(input string tag);
        repeat (120) @(negedge clk);
        chk({tag, " frame count"}, got_q.size(), exp_q.size());
        while (exp_q.size() > 0 && got_q.size() > 0)
            chk({tag, " frame"}, got_q.pop_front(), exp_q.pop_front());
        exp_q.delete(); got_q.delete();
    endtask

    // Per-clock comparison against the model, after each active edge.
    always @(posedge clk) begin
        #1;
        if (chk_on && rst_n) begin
            chk("R3 sw_out", sw0, m_en);
            chk("R12 fault", fp0, m_lat != 0);
            chk("R11 par sw_out", sw1, par_in);
            chk("R12 par fault", fp1, m_lat != 0);
        end
    end

    // Downstream frame decoder on the serial build's forward port.
    logic        p_sk = 1'b0, p_cs = 1'b1;
    logic [23:0] cap = '0;
    always @(negedge clk) begin
        if (!fcs0 && fsk0 && !p_sk) cap = {cap[22:0], fmo0};
        if (fcs0 && !p_cs) got_q.push_back(cap);
        p_sk = fsk0; p_cs = fcs0;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

    initial begin
        logic [7:0] r0, r1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 sw_out", sw0, 0);
        chk("R13 fault", fp0, 0);
        chk("R13 miso", miso0, 0);
        chk("R13 fwd_cs_n", fcs0, 1);
        chk_on = 1;

        // R3 enable all; R11 parallel twin keeps pins and reports them
        xfer(8'h00, 8'h03, 8'h0F, 24, r0, r1);
        chk("R3 enable all", sw0, 4'hF);
        chk("R8 write reply zero", r0, 0);
        chk("R11 par write reply", r1, 8'h05);
        // R4 / R8 status read
        xfer(8'h40, 8'h03, 8'h00, 24, r0, r1);
        chk("R4 status read", r0, exp_rd(8'h03, 0));
        chk("R11 par status read", r1, exp_rd(8'h03, 1));
        // R2 ignored command bits
        xfer(8'h8B, 8'h03, 8'h05, 24, r0, r1);
        chk("R2 junk cmd bits write", sw0, 4'h5);
        xfer(8'hCF, 8'h03, 8'hFF, 24, r0, r1);
        chk("R2 read leaves switches", sw0, 4'h5);
        chk("R2 read with junk bits", r0, 8'h05);
        // R1 short frame discarded
        xfer(8'h00, 8'h03, 8'h00, 20, r0, r1);
        chk("R1 short frame no change", sw0, 4'h5);
        par_in = 4'b1010;
        xfer(8'h00, 8'h03, 8'h00, 24, r0, r1);
        chk("R11 par write after pin change", r1, 8'h0A);
        chk("R3 disable all", sw0, 4'h0);

        // R5 R6 R12 sticky flags
        set_diag(16'h0120);
        set_diag(16'h0000);
        xfer(8'h40, 8'h01, 8'h00, 24, r0, r1);
        chk("R5 pair 1/2", r0, 8'h20);
        xfer(8'h40, 8'h02, 8'h00, 24, r0, r1);
        chk("R5 pair 3/4", r0, 8'h01);
        xfer(8'h40, 8'h00, 8'h00, 24, r0, r1);
        chk("R6 master", r0, 8'h06);
        chk("R12 fault held", fp0, 1);
        // R7 masked clear, write-only and read-only behaviour
        xfer(8'h00, 8'h05, 8'h02, 24, r0, r1);
        xfer(8'h40, 8'h00, 8'h00, 24, r0, r1);
        chk("R7 masked clear", r0, 8'h04);
        xfer(8'h40, 8'h05, 8'h00, 24, r0, r1);
        chk("R7 clear reads zero", r0, 0);
        xfer(8'h00, 8'h02, 8'h00, 24, r0, r1);
        xfer(8'h40, 8'h02, 8'h00, 24, r0, r1);
        chk("R7 read-only write ignored", r0, 8'h01);
        xfer(8'h40, 8'h07, 8'h00, 24, r0, r1);
        chk("R7 unmapped reads zero", r0, 0);
        // R7 set-dominant clear while input still high
        set_diag(16'h0100);
        xfer(8'h00, 8'h05, 8'h0F, 24, r0, r1);
        xfer(8'h40, 8'h02, 8'h00, 24, r0, r1);
        chk("R7 live fault survives clear", r0, 8'h01);
        set_diag(16'h0000);
        xfer(8'h00, 8'h05, 8'h04, 24, r0, r1);
        chk("R12 fault released", fp0, 0);

        // R9 R10 forwarding
        xfer(8'h10, 8'h03, 8'h0A, 24, r0, r1);
        chk("R9 no local write", sw0, 4'h0);
        check_fwd("R10 write fwd");
        xfer(8'h70, 8'h03, 8'h00, 24, r0, r1);
        chk("R9 fwd read miso zero", r0, 0);
        check_fwd("R9 read fwd");
        xfer(8'h20, 8'h01, 8'h0F, 20, r0, r1);
        check_fwd("R1 short fwd");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end
endmodule